// File: doc/BRIEF.md
# Paged ROM Chip-Select Decoder

This block sits between a processor with a 16-bit address space and the ROMs that hold its program. It watches the address bus and the valid-memory-address strobe, and produces registered chip selects. One select is for a fixed 16K ROM at the top of memory. Four more are for 32K ROMs that share a 16K banked window from 8000h to BFFFh.

A 3-bit page register is loaded by the processor through a write strobe. The two low page bits pick one of the four banked ROMs. The top page bit drives the extra address line of that ROM, which chooses its lower or upper half. This gives eight 16K banked pages plus the fixed ROM, 144K bytes in all.

All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge, using the page value held before that edge. The output enable goes active only on a read.

Top module: `paged_rom_select`

## Requirements
- R1: For an address from 8000h to BFFFh with vma high, exactly one bit of bank_sel is set, namely bit page[1:0]. fix_sel is low.
- R2: bank_a14 equals page[2] while a banked ROM is selected, and is 0 whenever no bit of bank_sel is set.
- R3: An address with bits 15 and 14 both high (C000h to FFFFh, which includes FFFEh and FFFFh) selects the fixed ROM when vma is high: fix_sel is 1 and bank_sel is 0.
- R4: While vma is low, fix_sel and every bank_sel bit are 0.
- R5: Addresses 0000h to 7FFFh select no ROM.
- R6: At most one of fix_sel and the bank_sel bits is high in any cycle.
- R7: oe_n is 0 only when rd_n was low and a ROM was selected in the same sampled cycle. Otherwise oe_n is 1.
- R8: A synchronous active-high reset clears the page register to 0, drives all selects and bank_a14 to 0, and drives oe_n to 1.
- R9: With pg_we high at a clock edge, pg_wdata loads into the page register. An access sampled at that same edge still uses the old page, and accesses from the next edge on use the new page.
- R10: Outputs are registered. They reflect addr, vma and rd_n sampled at the most recent rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Processor address bus |
| vma | input | 1 | Valid memory address strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| pg_we | input | 1 | Page register write strobe |
| pg_wdata | input | 3 | Page register write data: bits 1:0 pick the bank, bit 2 picks the half |
| fix_sel | output | 1 | Fixed ROM chip select, active high |
| bank_sel | output | 4 | One-hot chip selects for the banked ROMs |
| bank_a14 | output | 1 | Top address line of the selected banked ROM |
| oe_n | output | 1 | ROM output enable, active low |

## Verification
All eight page values are written in turn. After each write, the window is read at its two edges and in its middle. This separates a wrong bank decode from a wrong half bit. It also tests the window boundaries against the fixed region at C000h/FFFEh/FFFFh and the low region at 0000h/7FFFh.

The same window addresses are then presented with vma low and with rd_n high. These separate the select gating from the output-enable gating.

A page write issued together with an access shows whether the old page is used at that edge. A reset taken while the page is non-zero shows that the register clears.

// File: rtl/paged_rom_pkg.sv
package paged_rom_pkg;
  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_BANK  = 2'd1,
    RGN_FIXED = 2'd2
  } region_e;
endpackage

// File: rtl/page_register.sv
module page_register #(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (rst)      page <= '0;
    else if (we)  page <= wdata;
  end

  // R8: page is zero on the first edge after reset
  assert_page_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (page == '0));

  // R9: a write lands on the next edge
  assert_page_load_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && !$past(rst)) |-> (page == $past(wdata)));
endmodule

// File: rtl/region_decode.sv
module region_decode
  import paged_rom_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              vma,
  output region_e           region
);
  localparam logic [ADDR_W-1:0] TAG_MASK = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] WIN_PAT  = {2'b10, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] FIX_PAT  = {2'b11, {(ADDR_W-2){1'b0}}};

  logic [ADDR_W-1:0] tag;
  assign tag = addr & TAG_MASK;

  always_comb begin
    region = RGN_NONE;
    if (vma) begin
      if (tag == FIX_PAT)      region = RGN_FIXED;
      else if (tag == WIN_PAT) region = RGN_BANK;
    end
  end

  // R4: no region without a valid address
  always_comb assert_vma_gate_R4: assert (vma || region == RGN_NONE);
endmodule

// File: rtl/select_regs.sv
module select_regs
  import paged_rom_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  region_e                 region,
  input  logic                    rd_n,
  input  logic [BANK_W:0]         page,
  output logic                    fix_sel,
  output logic [(1<<BANK_W)-1:0]  bank_sel,
  output logic                    bank_a14,
  output logic                    oe_n
);
  localparam int NUM_BANKS = 1 << BANK_W;

  logic [NUM_BANKS-1:0] bank_d;
  logic                 fix_d;
  logic                 any_d;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_d[b] = (region == RGN_BANK) && (page[BANK_W-1:0] == BANK_W'(b));
  end

  assign fix_d = (region == RGN_FIXED);
  assign any_d = fix_d || (|bank_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_sel  <= 1'b0;
      bank_sel <= '0;
      bank_a14 <= 1'b0;
      oe_n     <= 1'b1;
    end else begin
      fix_sel  <= fix_d;
      bank_sel <= bank_d;
      bank_a14 <= (region == RGN_BANK) && page[BANK_W];
      oe_n     <= !(any_d && !rd_n);
    end
  end

  // R6: selects are mutually exclusive
  assert_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fix_sel, bank_sel}));

  // R7: output enable only alongside a select
  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (fix_sel || (|bank_sel)));

  // R2: half bit quiet when no bank is selected
  assert_a14_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !(|bank_sel) |-> !bank_a14);

  // R1: a window access selects exactly one bank
  assert_bank_one_R1: assert property (@(posedge clk) disable iff (rst)
    (region == RGN_BANK) |=> ($countones(bank_sel) == 1 && !fix_sel));
endmodule

// File: rtl/paged_rom_select.sv
module paged_rom_select
  import paged_rom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   vma,
  input  logic                   rd_n,
  input  logic                   pg_we,
  input  logic [BANK_W:0]        pg_wdata,
  output logic                   fix_sel,
  output logic [(1<<BANK_W)-1:0] bank_sel,
  output logic                   bank_a14,
  output logic                   oe_n
);
  localparam int PAGE_W = BANK_W + 1;

  logic [PAGE_W-1:0] page;
  region_e           region;

  page_register #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst(rst), .we(pg_we), .wdata(pg_wdata), .page(page)
  );

  region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .vma(vma), .region(region)
  );

  select_regs #(.BANK_W(BANK_W)) u_sel (
    .clk(clk), .rst(rst), .region(region), .rd_n(rd_n), .page(page),
    .fix_sel(fix_sel), .bank_sel(bank_sel), .bank_a14(bank_a14), .oe_n(oe_n)
  );

  // R5: low addresses select nothing (R10: one-cycle latency)
  assert_low_none_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(addr[ADDR_W-1]) |-> (!fix_sel && bank_sel == '0));

  // R4: no select after an invalid address cycle
  assert_vma_none_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(vma) |-> (!fix_sel && bank_sel == '0));

  // R3: fixed region selects the fixed ROM
  assert_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    (vma && addr[ADDR_W-1] && addr[ADDR_W-2]) |=> (fix_sel && bank_sel == '0));
endmodule

// File: tb/sim_paged_rom_select.sv
module sim_paged_rom_select;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        vma = 1'b0;
  logic        rd_n = 1'b1;
  logic        pg_we = 1'b0;
  logic [2:0]  pg_wdata = '0;
  logic        fix_sel;
  logic [3:0]  bank_sel;
  logic        bank_a14;
  logic        oe_n;

  int checks = 0;
  int errors = 0;
  int model_page = 0;
  int e_fix, e_bank, e_a14, e_oe;

  always #10 clk = ~clk;

  paged_rom_select u0 (
    .clk(clk), .rst(rst), .addr(addr), .vma(vma), .rd_n(rd_n),
    .pg_we(pg_we), .pg_wdata(pg_wdata), .fix_sel(fix_sel),
    .bank_sel(bank_sel), .bank_a14(bank_a14), .oe_n(oe_n)
  );

  task automatic compare(input string req);
    checks++;
    if (fix_sel !== e_fix[0] || bank_sel !== e_bank[3:0] ||
        bank_a14 !== e_a14[0] || oe_n !== e_oe[0]) begin
      errors++;
      $display("FAIL %s: got fix=%0b bank=%b a14=%0b oe_n=%0b expected fix=%0b bank=%b a14=%0b oe_n=%0b",
               req, fix_sel, bank_sel, bank_a14, oe_n,
               e_fix[0], e_bank[3:0], e_a14[0], e_oe[0]);
    end
    if ($countones({fix_sel, bank_sel}) > 1) begin
      errors++;
      $display("FAIL R6: selects fix=%0b bank=%b expected at most one high", fix_sel, bank_sel);
    end
  endtask

  // Drive one cycle of stimulus, let the edge pass, predict, then compare.
  task automatic step(input int a, input bit v, input bit r, input bit we,
                      input int wd, input bit rs, input string req);
    addr = a[15:0]; vma = v; rd_n = r; pg_we = we; pg_wdata = wd[2:0]; rst = rs;
    @(posedge clk);
    if (rs) begin
      e_fix = 0; e_bank = 0; e_a14 = 0; e_oe = 1;
      model_page = 0;
    end else begin
      e_fix = 0; e_bank = 0; e_a14 = 0;
      if (v && a >= 'hC000)
        e_fix = 1;
      else if (v && a >= 'h8000 && a <= 'hBFFF) begin
        e_bank = 1 << (model_page % 4);
        e_a14 = model_page / 4;
      end
      e_oe = (!r && (e_fix != 0 || e_bank != 0)) ? 0 : 1;
      if (we) model_page = wd;
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(0, 0, 1, 0, 0, 1, "R8");
    step(0, 0, 1, 0, 0, 1, "R8");
    // R8: reset state seen at the ports
    step('h8000, 1, 0, 0, 0, 0, "R8");
    for (int p = 0; p < 8; p++) begin
      step(0, 0, 1, 1, p, 0, "R9");
      step('h8000, 1, 0, 0, 0, 0, "R1");
      step('hA123, 1, 0, 0, 0, 0, "R2");
      step('hBFFF, 1, 0, 0, 0, 0, "R1");
      step('hC000, 1, 0, 0, 0, 0, "R3");
      step('hFFFE, 1, 0, 0, 0, 0, "R3");
      step('hFFFF, 1, 0, 0, 0, 0, "R3");
      step('h7FFF, 1, 0, 0, 0, 0, "R5");
      step('h0000, 1, 0, 0, 0, 0, "R5");
      step('h9000, 0, 0, 0, 0, 0, "R4");
      step('hFFFE, 0, 0, 0, 0, 0, "R4");
      step('h9000, 1, 1, 0, 0, 0, "R7");
      step('hFFFF, 1, 1, 0, 0, 0, "R7");
    end
    // R9: write together with access uses the old page, next uses new
    step(0, 0, 1, 1, 1, 0, "R9");
    step('h8800, 1, 0, 1, 6, 0, "R9");
    step('h8800, 1, 0, 0, 0, 0, "R9");
    // R10: a window access followed by an idle cycle deselects one cycle later
    step('hB000, 1, 0, 0, 0, 0, "R10");
    step('h0000, 0, 1, 0, 0, 0, "R10");
    // R8: reset with a non-zero page clears it
    step(0, 0, 1, 1, 7, 0, "R8");
    step('hA000, 1, 0, 0, 0, 1, "R8");
    step('hA000, 1, 0, 0, 0, 0, "R8");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule